// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM with one bus for write data and another for read data. Each access moves a burst of exactly two data beats. The block works in command slots of two beat edges on a single clock, and that pair of edges stands in for the rising and falling halves of a double-data-rate cycle. The first edge of each slot is the command edge. Counting from reset release, the slots follow each other without a gap.

When the active-low load strobe is sampled low on a command edge, the block accepts a command. The read/write select then chooses a read (high) or a write (low), and the address names one internal word that is twice the bus width. Write data arrives in the slot after the command, one beat on each edge, together with active-low lane enables for that beat. The two beats are joined and committed to the array in a single update. Read data leaves in the slot after the command as two beats. An output-enable marks the slots in which the read bus carries data. An echo clock that never stops marks which beat is on the bus.

Top module: `sio_b2_sram`

## Requirements
- R1: While reset is asserted, `qOe` is 0, `qData` is 0 and `echoClk` is 0. The first rising edge after reset is released is a command edge, and each later command edge follows two edges after the one before it.
- R2: A slot whose command edge samples `ldN` high is a deselect. It leaves the array unchanged, even when the select is low and the lane enables are low.
- R3: After a read of word A, `qData` carries bits [DATA_W-1:0] of word A from the first edge of the next slot and bits [2*DATA_W-1:DATA_W] from its second edge.
- R4: After a write to word A, the beat sampled on the first edge of the next slot goes to the low half of word A and the beat sampled on its second edge goes to the high half. Both halves are committed together.
- R5: Lane enables `bweN` are active low and are sampled with each write beat. Lane l covers bits [8l+7:8l] of a beat. A lane is updated only in the beats whose enable was 0, so the lane can be updated in both beats, only the first, only the second, or neither.
- R6: A write whose lane enables are all 1 in both beats leaves the word unchanged.
- R7: A read issued in the slot right after a write to the same word returns the newly written data.
- R8: `qOe` is 1 for both beats of the slot that follows a read. It is 0 for both beats of the slot that follows a write or a deselect, including when a read came before that command.
- R9: `echoClk` is 1 during the first beat of every slot and 0 during the second, whatever commands are issued.
- R10: Each address value selects its own double-width word. Writing one word does not change another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; two edges make one command slot |
| rstN | input | 1 | Synchronous active-low reset |
| ldN | input | 1 | Active-low command load strobe |
| rdWrN | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Double-width word address |
| dIn | input | DATA_W | Write data beat |
| bweN | input | DATA_W/8 | Active-low lane write enables for the current beat |
| qData | output | DATA_W | Read data beat, 0 when not driven |
| qOe | output | 1 | Read bus driven |
| echoClk | output | 1 | Beat marker that never stops: 1 on first beat, 0 on second |

## Verification
A command is sampled on a slot's first edge. Its results are due in the following slot: read beat 0 and `qOe` after that slot's first edge, read beat 1 after its second edge. Write beats are consumed on those same two edges. The bench drives every input on a falling edge. It samples the outputs on the falling edge that follows each result edge, so each value is checked in the half cycle it is due. Expected words come from a reference array in the bench. That array is updated lane by lane from the same beats and enables only after a write's second beat. Back-to-back write/read pairs therefore check forwarding against that timing.

// File: rtl/sio_b2_pkg.sv
package sio_b2_pkg;
  // strobes issued by the slot sequencer to the datapath on each edge
  typedef struct packed {
    logic captureLo;  // first write beat is present on dIn/bweN
    logic commit;     // second write beat present: update the array word
    logic loadRead;   // fetch read word, present its low beat
    logic shiftHi;    // present the held high beat
  } strobe_t;
endpackage

// File: rtl/sio_b2_ctrl.sv
module sio_b2_ctrl
  import sio_b2_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldN,
  input  logic              rdWrN,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           st,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              qOe,
  output logic              echoClk
);
  logic              atB;       // next edge is the second edge of a slot
  logic              cmdWr, cmdRd, dataWr;
  logic [ADDR_W-1:0] cmdAddr, dataAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      atB      <= 1'b0;
      cmdWr    <= 1'b0;
      cmdRd    <= 1'b0;
      dataWr   <= 1'b0;
      cmdAddr  <= '0;
      dataAddr <= '0;
      qOe      <= 1'b0;
      echoClk  <= 1'b0;
    end else begin
      atB     <= ~atB;
      echoClk <= ~atB;
      if (!atB) begin
        cmdWr    <= !ldN && !rdWrN;
        cmdRd    <= !ldN && rdWrN;
        cmdAddr  <= addr;
        dataWr   <= cmdWr;
        dataAddr <= cmdAddr;
        qOe      <= cmdRd;
      end
    end
  end

  always_comb begin
    st.captureLo = !atB && cmdWr;
    st.loadRead  = !atB && cmdRd;
    st.commit    = atB && dataWr;
    st.shiftHi   = atB && qOe;
  end

  assign wrAddr = dataAddr;
  assign rdAddr = cmdAddr;

  // R9: echo clock changes level on every edge once reset is released
  p_echo_alternates_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (echoClk != $past(echoClk)));

  // R8: output enable holds across both beats of a slot
  p_oe_whole_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!echoClk && $past(rstN)) |-> (qOe == $past(qOe)));

  // R8: a write sampled on a command edge leaves the next slot undriven
  p_oe_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!atB && !ldN && !rdWrN) |-> ##3 !qOe);

  // R2: a deselect never produces a commit in the next slot
  p_deselect_no_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!atB && ldN) |-> ##3 !st.commit);
endmodule

// File: rtl/sio_b2_datapath.sv
module sio_b2_datapath
  import sio_b2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dIn,
  input  logic [DATA_W/LANE_W-1:0] bweN,
  output logic [DATA_W-1:0] qData
);
  localparam int LANES  = DATA_W / LANE_W;
  localparam int WORD_W = 2 * DATA_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] loData, hiHold;
  logic [LANES-1:0]  loMaskN;
  logic [WORD_W-1:0] bitMask, newData, mergedWord, rdWord;

  assign newData = {dIn, loData};
  assign rdWord  = mem[rdAddr];

  // expand per-beat lane enables to a bit mask over the double word
  for (genvar b = 0; b < 2; b++) begin : g_beat
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic laneOn;
      assign laneOn = (b == 0) ? !loMaskN[l] : !bweN[l];
      assign bitMask[b*DATA_W + l*LANE_W +: LANE_W] = {LANE_W{laneOn}};
    end
  end

  assign mergedWord = (mem[wrAddr] & ~bitMask) | (newData & bitMask);

  always_ff @(posedge clk) begin
    if (st.commit) mem[wrAddr] <= mergedWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loData  <= '0;
      loMaskN <= '1;
      hiHold  <= '0;
      qData   <= '0;
    end else begin
      if (st.captureLo) begin
        loData  <= dIn;
        loMaskN <= bweN;
      end
      if (st.loadRead) begin
        qData  <= rdWord[DATA_W-1:0];
        hiHold <= rdWord[WORD_W-1:DATA_W];
      end else if (st.shiftHi) begin
        qData <= hiHold;
      end else begin
        qData <= '0;
      end
    end
  end

  // R4: a commit always follows a first-beat capture on the previous edge
  p_commit_after_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> $past(st.captureLo));

  // R3: the high beat is only presented right after a read fetch
  p_high_after_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.shiftHi |-> $past(st.loadRead));

  // R6: a commit with no lane enabled leaves the word as it was
  p_abort_keeps_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit && (&loMaskN) && (&bweN)) |=>
      (mem[$past(wrAddr)] == $past(mem[wrAddr])));
endmodule

// File: rtl/sio_b2_sram.sv
module sio_b2_sram
  import sio_b2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ldN,
  input  logic                     rdWrN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        dIn,
  input  logic [DATA_W/LANE_W-1:0] bweN,
  output logic [DATA_W-1:0]        qData,
  output logic                     qOe,
  output logic                     echoClk
);
  strobe_t           st;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  sio_b2_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ldN(ldN), .rdWrN(rdWrN), .addr(addr),
    .st(st), .wrAddr(wrAddr), .rdAddr(rdAddr), .qOe(qOe), .echoClk(echoClk)
  );

  sio_b2_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dIn(dIn), .bweN(bweN), .qData(qData)
  );

  // R8: nothing appears on the read bus while it is not enabled
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !qOe |-> (qData == '0));
endmodule

// File: tb/test_sio_b2_sram.sv
module test_sio_b2_sram;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NL = DW / 8;

  logic          clk = 1'b0;
  logic          rstN, ldN, rdWrN;
  logic [AW-1:0] addr;
  logic [DW-1:0] dIn;
  logic [NL-1:0] bweN;
  logic [DW-1:0] qData;
  logic          qOe, echoClk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [2*DW-1:0] refMem [1<<AW];
  // write waiting for its beats, and read waiting for its output slot
  bit            pWr = 0, pRd = 0;
  logic [AW-1:0] pAddr = '0;
  logic [DW-1:0] pD0 = '0, pD1 = '0;
  logic [NL-1:0] pM0 = '1, pM1 = '1;

  always #5 clk = ~clk;

  sio_b2_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) i_sio_b2_sram (
    .clk(clk), .rstN(rstN), .ldN(ldN), .rdWrN(rdWrN), .addr(addr),
    .dIn(dIn), .bweN(bweN), .qData(qData), .qOe(qOe), .echoClk(echoClk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*DW-1:0] mergeRef(input logic [2*DW-1:0] old,
      input logic [DW-1:0] d0, input logic [NL-1:0] m0,
      input logic [DW-1:0] d1, input logic [NL-1:0] m1);
    logic [2*DW-1:0] w = old;
    for (int l = 0; l < NL; l++) begin
      if (!m0[l]) w[l*8 +: 8] = d0[l*8 +: 8];
      if (!m1[l]) w[DW + l*8 +: 8] = d1[l*8 +: 8];
    end
    return w;
  endfunction

  // one command slot; outputs and write beats belong to the previous slot
  task automatic slot(input bit load, input bit rd, input logic [AW-1:0] a,
      input logic [DW-1:0] d0 = '0, input logic [NL-1:0] m0 = '1,
      input logic [DW-1:0] d1 = '0, input logic [NL-1:0] m1 = '1);
    logic [2*DW-1:0] exp;
    bit expOe;
    expOe = pRd;
    exp = pRd ? refMem[pAddr] : '0;
    ldN = !load; rdWrN = rd; addr = a;
    dIn = pWr ? pD0 : 16'hDEAD; bweN = pWr ? pM0 : '0;
    @(posedge clk); @(negedge clk);
    chk("R8 oe beat0", qOe, expOe);
    chk("R9 echo beat0", echoClk, 1'b1);
    chk("R3/R7 data beat0", qData, exp[DW-1:0]);
    ldN = 1'b0; rdWrN = 1'b0; addr = ~a;   // ignored on second edge
    dIn = pWr ? pD1 : 16'hBEEF; bweN = pWr ? pM1 : '0;
    @(posedge clk); @(negedge clk);
    chk("R8 oe beat1", qOe, expOe);
    chk("R9 echo beat1", echoClk, 1'b0);
    chk("R3/R7 data beat1", qData, exp[2*DW-1:DW]);
    if (pWr) refMem[pAddr] = mergeRef(refMem[pAddr], pD0, pM0, pD1, pM1);
    pWr = load && !rd; pRd = load && rd; pAddr = a;
    pD0 = d0; pM0 = m0; pD1 = d1; pM1 = m1;
  endtask

  task automatic idle(); slot(0, 0, '0); endtask

  task automatic t_reset();
    rstN = 0; ldN = 1; rdWrN = 1; addr = '0; dIn = '0; bweN = '1;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", qOe, 1'b0);
    chk("R1 data in reset", qData, '0);
    chk("R1 echo in reset", echoClk, 1'b0);
    rstN = 1;
  endtask

  task automatic t_fill();  // R4, R10
    for (int i = 0; i < 8; i++)
      slot(1, 0, AW'(i), DW'(16'h1100 + i), '0, DW'(16'hA0F0 + 16*i), '0);
    for (int i = 0; i < 8; i++) slot(1, 1, AW'(i));
    idle();
  endtask

  task automatic t_lanes();  // R5
    slot(1, 0, 6'd2, 16'h1234, 2'b10, 16'h5678, 2'b01); // lane0 beat0, lane1 beat1
    slot(1, 0, 6'd3, 16'hCAFE, 2'b00, 16'hF00D, 2'b11); // first beat only
    slot(1, 0, 6'd4, 16'h7777, 2'b11, 16'h9999, 2'b00); // second beat only
    slot(1, 1, 6'd2); slot(1, 1, 6'd3); slot(1, 1, 6'd4);
    idle();
  endtask

  task automatic t_abort();  // R6
    slot(1, 0, 6'd5, 16'hFFFF, 2'b11, 16'hFFFF, 2'b11);
    idle();
    slot(1, 1, 6'd5);
    idle();
  endtask

  task automatic t_deselect();  // R2: prior write data beats carry low enables
    slot(0, 0, 6'd6, 16'h0BAD, 2'b00, 16'h0BAD, 2'b00);
    slot(0, 0, 6'd6);
    slot(1, 1, 6'd6);
    idle();
  endtask

  task automatic t_backToBack();  // R7, R8
    slot(1, 0, 6'd7, 16'h4242, 2'b00, 16'h2424, 2'b00);
    slot(1, 1, 6'd7);                                  // read right after write
    slot(1, 0, 6'd7, 16'h0001, 2'b01, 16'h0002, 2'b10); // write after read: oe drops
    slot(1, 1, 6'd7);
    slot(1, 1, 6'd1);                                  // read after read
    slot(0, 1, 6'd0);                                  // deselect after read
    slot(1, 1, 6'd0);
    idle();
  endtask

  initial begin
    t_reset();
    t_fill();
    t_lanes();
    t_abort();
    t_deselect();
    t_backToBack();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule